// File: doc/BRIEF.md
# Configurable LUT Logic Element

This block models a single programmable logic cell in its general-logic mode. A four-input lookup table picks one bit of a 16-bit configuration mask, using the four LUT inputs as the index. The same bit is driven out as the cell's combinational result and on a LUT-chain output. The next cell can use that chain output without going through routing.

Two configuration bits change where LUT inputs come from. One bit lets the third LUT input take a carry-in in place of its data pin. The other bit lets the fourth LUT input take the cell's own register output as feedback.

Next to the LUT sits one register. It has a clock enable, a synchronous clear, a synchronous load from a register-chain input, an asynchronous clear and an asynchronous load. The asynchronous load takes its value from the third data pin. In packed operation the register stores a separate data input, while the LUT keeps serving unrelated combinational logic. The register value goes out as both the registered result and the register-chain output.

Top module: `lut_cell`

## Requirements
- R1: With both source-select bits clear, `comb_out` equals `cfg_mask[idx]` where idx = {data_in[3], data_in[2], data_in[1], data_in[0]} (bit 3 most significant).
- R2: With `cfg_carry_sel` high, LUT index bit 2 is `carry_in` and `data_in[2]` has no effect on `comb_out`; with it low, `carry_in` has no effect.
- R3: With `cfg_fb_sel` high, LUT index bit 3 is the current `reg_out` and `data_in[3]` has no effect on `comb_out`.
- R4: `lut_chain_out` always carries the same value as `comb_out`.
- R5: While `arst_clr` is high, `reg_out` is 0 at once, without a clock edge, whatever `arst_load` and the synchronous controls do.
- R6: When `arst_load` rises with `arst_clr` low, `reg_out` takes `data_in[2]` without waiting for a clock. On every clock edge while `arst_load` stays high, it reloads `data_in[2]` and ignores the synchronous controls.
- R7: On a rising clock edge with `ena` high and no asynchronous control, `sclr` high makes `reg_out` 0, even when `sload` is also high.
- R8: On such an edge with `sclr` low and `sload` high, `reg_out` takes `chain_in`.
- R9: On such an edge with `sclr` and `sload` low, `reg_out` takes the LUT result, or `pk_data` when `cfg_packed` is high; packed operation leaves `comb_out` unchanged.
- R10: On a rising edge with `ena` low and no asynchronous control, `reg_out` holds, even when `sclr` or `sload` is high.
- R11: `reg_chain_out` always carries the same value as `reg_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| arst_clr | input | 1 | Asynchronous clear, active high, highest priority |
| arst_load | input | 1 | Asynchronous load of data_in[2], active high |
| cfg_mask | input | 16 | LUT truth-table mask |
| cfg_carry_sel | input | 1 | 1: LUT input 2 from carry_in |
| cfg_fb_sel | input | 1 | 1: LUT input 3 from register output |
| cfg_packed | input | 1 | 1: register captures pk_data instead of LUT result |
| data_in | input | 4 | LUT data pins |
| carry_in | input | 1 | Carry from the previous cell |
| pk_data | input | 1 | Independent register data for packed operation |
| chain_in | input | 1 | Register-chain input from the previous cell |
| ena | input | 1 | Clock enable |
| sclr | input | 1 | Synchronous clear |
| sload | input | 1 | Synchronous load of chain_in |
| comb_out | output | 1 | Combinational LUT result |
| lut_chain_out | output | 1 | LUT result to the next cell |
| reg_out | output | 1 | Registered result |
| reg_chain_out | output | 1 | Register value to the next cell |

## Verification
Some register controls can act in the same cycle, so their priorities are tested directly. One clock edge can see synchronous clear and synchronous load together. An asynchronous load can be held high across an edge while the enable and synchronous load are high. An asynchronous clear can come on while an asynchronous load is already active. The bench builds each of these overlaps on purpose and checks `reg_out` right after the asynchronous change and again after the next edge. The expected values come from a reference model in the bench that applies the stated priority order. Random cycles mix enable, clear, load and packed selection, so the same priority chain is also covered in many other combinations.

// File: rtl/lec_pkg.sv
package lec_pkg;

  // Source the register picks on a clock edge.
  typedef enum logic [1:0] {
    NXT_HOLD  = 2'd0,
    NXT_CLEAR = 2'd1,
    NXT_CHAIN = 2'd2,
    NXT_DATA  = 2'd3
  } next_src_e;

  // Clocked priority: enable gates everything, clear beats chain load.
  function automatic next_src_e pick_next(input logic ena, input logic sclr,
                                          input logic sload);
    next_src_e s;
    if (!ena)       s = NXT_HOLD;
    else if (sclr)  s = NXT_CLEAR;
    else if (sload) s = NXT_CHAIN;
    else            s = NXT_DATA;
    return s;
  endfunction

  // Data captured in the NXT_DATA case.
  function automatic logic pick_data(input logic packed_sel, input logic pk_data,
                                     input logic lut_y);
    return packed_sel ? pk_data : lut_y;
  endfunction

endpackage

// File: rtl/lec_input_sel.sv
module lec_input_sel #(
  parameter int K         = 4,
  parameter int CARRY_POS = 2,
  parameter int FB_POS    = K - 1
) (
  input  logic [K-1:0] data_in,
  input  logic         carry_in,
  input  logic         fb_q,
  input  logic         cfg_carry_sel,
  input  logic         cfg_fb_sel,
  output logic [K-1:0] lut_idx
);

  for (genvar i = 0; i < K; i++) begin : g_pos
    if (i == CARRY_POS) begin : g_carry
      assign lut_idx[i] = cfg_carry_sel ? carry_in : data_in[i];
    end else if (i == FB_POS) begin : g_fb
      assign lut_idx[i] = cfg_fb_sel ? fb_q : data_in[i];
    end else begin : g_pass
      assign lut_idx[i] = data_in[i];
    end
  end

endmodule

// File: rtl/lec_lut.sv
module lec_lut #(
  parameter int K = 4,
  localparam int N = 1 << K,
  localparam int NODES = 2 * N - 1
) (
  input  logic [N-1:0] mask,
  input  logic [K-1:0] idx,
  output logic         y
);

  // Heap-ordered mux tree: node i has children 2i+1 (select 0) and 2i+2 (select 1).
  logic [NODES-1:0] node;

  for (genvar p = 0; p < N; p++) begin : g_leaf
    assign node[N - 1 + p] = mask[p];
  end

  for (genvar i = 0; i < N - 1; i++) begin : g_mux
    localparam int DEPTH = $clog2(i + 2) - 1;
    assign node[i] = idx[K - 1 - DEPTH] ? node[2 * i + 2] : node[2 * i + 1];
  end

  assign y = node[0];

endmodule

// File: rtl/lec_register.sv
module lec_register (
  input  logic clk,
  input  logic aclr,
  input  logic aload,
  input  logic adata,
  input  logic ena,
  input  logic sclr,
  input  logic sload,
  input  logic chain_in,
  input  logic packed_sel,
  input  logic pk_data,
  input  logic lut_y,
  output logic q,
  output logic evt_clear,
  output logic evt_chain,
  output logic evt_data
);

  import lec_pkg::*;

  next_src_e src;
  logic      cap_d;

  always_comb begin
    src   = pick_next(ena, sclr, sload);
    cap_d = pick_data(packed_sel, pk_data, lut_y);
  end

  assign evt_clear = (src == NXT_CLEAR);
  assign evt_chain = (src == NXT_CHAIN);
  assign evt_data  = (src == NXT_DATA);

  always_ff @(posedge clk or posedge aclr or posedge aload) begin
    if (aclr)       q <= 1'b0;
    else if (aload) q <= adata;
    else begin
      unique case (src)
        NXT_HOLD:  q <= q;
        NXT_CLEAR: q <= 1'b0;
        NXT_CHAIN: q <= chain_in;
        NXT_DATA:  q <= cap_d;
        default:   q <= q;
      endcase
    end
  end

endmodule

// File: rtl/lut_cell.sv
module lut_cell #(
  parameter int K         = 4,
  parameter int CARRY_POS = 2,
  localparam int MASK_W   = 1 << K
) (
  input  logic              clk,
  input  logic              arst_clr,
  input  logic              arst_load,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic              cfg_carry_sel,
  input  logic              cfg_fb_sel,
  input  logic              cfg_packed,
  input  logic [K-1:0]      data_in,
  input  logic              carry_in,
  input  logic              pk_data,
  input  logic              chain_in,
  input  logic              ena,
  input  logic              sclr,
  input  logic              sload,
  output logic              comb_out,
  output logic              lut_chain_out,
  output logic              reg_out,
  output logic              reg_chain_out
);

  logic [K-1:0] lut_idx;
  logic         lut_y;
  logic         q;
  logic         evt_clear;
  logic         evt_chain;
  logic         evt_data;

  lec_input_sel #(.K(K), .CARRY_POS(CARRY_POS), .FB_POS(K - 1)) u_sel (
    .data_in       (data_in),
    .carry_in      (carry_in),
    .fb_q          (q),
    .cfg_carry_sel (cfg_carry_sel),
    .cfg_fb_sel    (cfg_fb_sel),
    .lut_idx       (lut_idx)
  );

  lec_lut #(.K(K)) u_lut (
    .mask (cfg_mask),
    .idx  (lut_idx),
    .y    (lut_y)
  );

  lec_register u_reg (
    .clk        (clk),
    .aclr       (arst_clr),
    .aload      (arst_load),
    .adata      (data_in[CARRY_POS]),
    .ena        (ena),
    .sclr       (sclr),
    .sload      (sload),
    .chain_in   (chain_in),
    .packed_sel (cfg_packed),
    .pk_data    (pk_data),
    .lut_y      (lut_y),
    .q          (q),
    .evt_clear  (evt_clear),
    .evt_chain  (evt_chain),
    .evt_data   (evt_data)
  );

  assign comb_out      = lut_y;
  assign lut_chain_out = lut_y;
  assign reg_out       = q;
  assign reg_chain_out = q;

endmodule

// File: rtl/lec_checker.sv
module lec_checker #(
  parameter int K         = 4,
  parameter int CARRY_POS = 2,
  localparam int MASK_W   = 1 << K
) (
  input logic              clk,
  input logic              arst_clr,
  input logic              arst_load,
  input logic [MASK_W-1:0] cfg_mask,
  input logic              cfg_packed,
  input logic [K-1:0]      data_in,
  input logic [K-1:0]      lut_idx,
  input logic              pk_data,
  input logic              chain_in,
  input logic              comb_out,
  input logic              reg_out,
  input logic              evt_clear,
  input logic              evt_chain,
  input logic              evt_data
);

  // R1: tree output agrees with a direct mask index
  p_lut_index_r1: assert property (@(posedge clk) disable iff (arst_clr)
    comb_out == cfg_mask[lut_idx]);

  // R6: while async load is held, register mirrors data pin 2
  p_aload_data_r6: assert property (@(posedge clk) disable iff (arst_clr)
    arst_load |-> reg_out == data_in[CARRY_POS]);

  // R7: synchronous clear event yields zero
  p_sclr_zero_r7: assert property (@(posedge clk) disable iff (arst_clr)
    (evt_clear && !arst_load) |=> (arst_load || reg_out == 1'b0));

  // R8: chain load event takes chain_in
  p_sload_chain_r8: assert property (@(posedge clk) disable iff (arst_clr)
    (evt_chain && !arst_load) |=> (arst_load || reg_out == $past(chain_in)));

  // R9: packed capture takes pk_data
  p_packed_cap_r9: assert property (@(posedge clk) disable iff (arst_clr)
    (evt_data && cfg_packed && !arst_load) |=> (arst_load || reg_out == $past(pk_data)));

  // R10: no event means hold
  p_hold_r10: assert property (@(posedge clk) disable iff (arst_clr)
    (!evt_clear && !evt_chain && !evt_data && !arst_load)
      |=> (arst_load || reg_out == $past(reg_out)));

endmodule

bind lut_cell lec_checker #(.K(K), .CARRY_POS(CARRY_POS)) u_chk (.*);

// File: tb/sim_lut_cell.sv
`timescale 1ns/1ps
module sim_lut_cell;

  logic        clk = 1'b0;
  logic        arst_clr, arst_load;
  logic [15:0] cfg_mask;
  logic        cfg_carry_sel, cfg_fb_sel, cfg_packed;
  logic [3:0]  data_in;
  logic        carry_in, pk_data, chain_in, ena, sclr, sload;
  logic        comb_out, lut_chain_out, reg_out, reg_chain_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic q_m;

  always #5 clk = ~clk;

  lut_cell u0 (
    .clk(clk), .arst_clr(arst_clr), .arst_load(arst_load), .cfg_mask(cfg_mask),
    .cfg_carry_sel(cfg_carry_sel), .cfg_fb_sel(cfg_fb_sel), .cfg_packed(cfg_packed),
    .data_in(data_in), .carry_in(carry_in), .pk_data(pk_data), .chain_in(chain_in),
    .ena(ena), .sclr(sclr), .sload(sload), .comb_out(comb_out),
    .lut_chain_out(lut_chain_out), .reg_out(reg_out), .reg_chain_out(reg_chain_out)
  );

  function automatic logic lut_ref(input logic [15:0] m, input logic [3:0] ix);
    logic [15:0] sh;
    sh = m >> ix;
    return sh[0];
  endfunction

  function automatic logic [3:0] idx_ref(input logic [3:0] d, input logic csel,
                                         input logic cin, input logic fsel,
                                         input logic q);
    logic [3:0] r;
    r = d;
    if (csel) r[2] = cin;
    if (fsel) r[3] = q;
    return r;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check_reg(input string req);
    chk(req, reg_out, q_m);
    chk("R11", reg_chain_out, reg_out);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic exp_y;
    void'($urandom(32'd20240611));
    arst_clr = 1'b1; arst_load = 1'b0; cfg_mask = 16'h0;
    cfg_carry_sel = 1'b0; cfg_fb_sel = 1'b0; cfg_packed = 1'b0;
    data_in = 4'h0; carry_in = 1'b0; pk_data = 1'b0; chain_in = 1'b0;
    ena = 1'b0; sclr = 1'b0; sload = 1'b0;
    q_m = 1'b0;
    step(); step();
    check_reg("R5");
    arst_clr = 1'b0;
    step();

    // R1 / R4: full sweep over several masks
    for (int m = 0; m < 5; m++) begin
      cfg_mask = (m == 0) ? 16'h6996 : 16'($urandom);
      for (int v = 0; v < 16; v++) begin
        data_in = 4'(v);
        #1;
        exp_y = lut_ref(cfg_mask, 4'(v));
        chk("R1", comb_out, exp_y);
        chk("R4", lut_chain_out, exp_y);
      end
    end

    // R2: carry replaces data pin 2, and is ignored when not selected
    cfg_mask = 16'hA5C3;
    for (int v = 0; v < 16; v++) begin
      data_in = 4'(v);
      carry_in = ~data_in[2];
      cfg_carry_sel = 1'b1;
      #1;
      chk("R2", comb_out, lut_ref(cfg_mask, {data_in[3], ~data_in[2], data_in[1:0]}));
      cfg_carry_sel = 1'b0;
      #1;
      chk("R2", comb_out, lut_ref(cfg_mask, data_in));
    end

    // R3: feedback from the register replaces data pin 3
    cfg_mask = 16'hFF00;
    cfg_fb_sel = 1'b1;
    data_in = 4'b1000;
    #1;
    chk("R3", comb_out, 1'b0);
    chain_in = 1'b1; sload = 1'b1; ena = 1'b1;
    step();
    q_m = 1'b1;
    check_reg("R8");
    ena = 1'b0; sload = 1'b0; chain_in = 1'b0;
    data_in = 4'b0000;
    #1;
    chk("R3", comb_out, 1'b1);
    cfg_fb_sel = 1'b0;

    // random clocked traffic
    for (int n = 0; n < 400; n++) begin
      string tag;
      logic  ly;
      if (n % 25 == 0) cfg_mask = 16'($urandom);
      data_in       = 4'($urandom);
      carry_in      = 1'($urandom);
      cfg_carry_sel = 1'($urandom);
      cfg_fb_sel    = 1'($urandom);
      cfg_packed    = 1'($urandom);
      pk_data       = 1'($urandom);
      chain_in      = 1'($urandom);
      ena           = ($urandom % 10) < 7;
      sclr          = ($urandom % 10) < 2;
      sload         = ($urandom % 10) < 3;
      #1;
      ly = lut_ref(cfg_mask, idx_ref(data_in, cfg_carry_sel, carry_in, cfg_fb_sel, q_m));
      chk("R1", comb_out, ly);
      if (!ena)       begin tag = "R10"; end
      else if (sclr)  begin tag = "R7";  q_m = 1'b0; end
      else if (sload) begin tag = "R8";  q_m = chain_in; end
      else            begin tag = "R9";  q_m = cfg_packed ? pk_data : ly; end
      step();
      check_reg(tag);
    end
    cfg_carry_sel = 1'b0; cfg_fb_sel = 1'b0; cfg_packed = 1'b0;

    // R7: clear wins over load
    ena = 1'b1; sclr = 1'b0; sload = 1'b1; chain_in = 1'b1;
    step(); q_m = 1'b1; check_reg("R8");
    sclr = 1'b1;
    step(); q_m = 1'b0; check_reg("R7");

    // R9: packed capture while LUT keeps serving its own logic
    sclr = 1'b0; sload = 1'b0;
    cfg_mask = 16'hFFFF; cfg_packed = 1'b1; pk_data = 1'b0;
    step(); check_reg("R9");
    chk("R9", comb_out, 1'b1);
    pk_data = 1'b1; cfg_mask = 16'h0000;
    step(); q_m = 1'b1; check_reg("R9");
    chk("R9", comb_out, 1'b0);
    cfg_packed = 1'b0; cfg_mask = 16'hFFFF;
    step(); check_reg("R9");

    // R10: enable low blocks clear and load
    ena = 1'b0; sclr = 1'b1; sload = 1'b1; chain_in = 1'b0;
    step(); check_reg("R10");
    step(); check_reg("R10");
    sclr = 1'b0; sload = 1'b0;
    step(); check_reg("R10");

    // R6: async load from data pin 2, no clock needed
    cfg_mask = 16'h0000;
    step(); q_m = 1'b0; chk("R9", reg_out, 1'b1);
    ena = 1'b1; step(); q_m = 1'b0; check_reg("R9");
    ena = 1'b0; step(); check_reg("R10");
    data_in = 4'b0100;
    arst_load = 1'b1;
    #1; q_m = 1'b1; check_reg("R6");
    ena = 1'b1; sload = 1'b1; chain_in = 1'b0;
    step(); check_reg("R6");
    // R5: clear overrides an active load, immediately
    arst_clr = 1'b1;
    #1; q_m = 1'b0; check_reg("R5");
    step(); check_reg("R5");
    arst_clr = 1'b0; arst_load = 1'b0; ena = 1'b0; sload = 1'b0;
    step(); check_reg("R10");
    // R5: async clear from a set register, between edges
    chain_in = 1'b1; sload = 1'b1; ena = 1'b1;
    step(); q_m = 1'b1; check_reg("R8");
    ena = 1'b0; sload = 1'b0;
    step(); check_reg("R10");
    arst_clr = 1'b1;
    #1; q_m = 1'b0; check_reg("R5");
    step();
    arst_clr = 1'b0;
    step(); check_reg("R10");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule